// File: doc/BRIEF.md
# Unicast Receive Address Filter

This block keeps a small table of station addresses, each entry with its own valid flag, and compares the 48-bit destination address of every incoming frame header against all valid entries at once. A frame parser presents the destination address on a 48-bit bus together with a one-cycle strobe. One cycle later the filter reports whether any entry hit and, if so, the index of the hit entry.

Software fills the table through a simple word-wide register port. Each entry occupies two 32-bit registers. The low register carries address bytes 0 to 3. The high register carries bytes 4 and 5 plus the valid flag. Entries are held in little-endian byte order. The valid flag is never written directly: the block sets it whenever the 48-bit address committed to an entry is nonzero and clears it otherwise. A low-word write is held aside until the high word of the same entry arrives, so the matcher never sees a half-updated address. The usual bring-up programs entry 0 with the station's own address and writes zero to every other entry.

Top module: `ucast_addr_filter`

## Requirements
- R1: After reset every entry is cleared and invalid, every register reads back zero, `res_valid` is low and no frame can hit.
- R2: Register address bit 0 selects the word (0 = low, 1 = high) and the upper bits select the entry. The low word holds byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. On `dest_addr`, byte 0 (the first byte on the wire) is bits 47:40 and byte 5 is bits 7:0.
- R3: The high word holds byte 4 in bits 7:0, byte 5 in bits 15:8 and the valid flag in bit 31. Bits 30:16 always read as zero, and write data in bits 31:16 is ignored.
- R4: A high-word write sets the entry's valid flag only if the committed 48-bit address is nonzero. An all-zero entry is invalid, and an all-zero destination never hits.
- R5: A low-word write changes neither matching nor readback of the entry. It takes effect together with the next high-word write to the same entry. A high-word write to any other entry keeps that entry's existing low word.
- R6: An entry hits only when it is valid and all 48 address bits equal `dest_addr`.
- R7: When several entries hit, the lowest index is reported.
- R8: `res_valid` pulses exactly one cycle after `dest_valid`. `res_hit` is high only with `res_valid`. On a miss, `res_hit` and `res_idx` are both zero.
- R9: A frame strobe in the same cycle as a high-word write is compared against the table as it stood before that write.
- R10: A register read returns its data one cycle after `reg_rd`. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | IDX_W+1 | {entry index, word select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| dest_valid | input | 1 | Frame destination address strobe |
| dest_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Lookup result strobe |
| res_hit | output | 1 | An entry matched |
| res_idx | output | IDX_W | Lowest matching entry index, zero on miss |

## Verification
The bench builds the filter with the default of 16 entries. That puts the last entry (index 15) and the top bit of the index field within reach, and allows duplicate addresses to be placed far apart to exercise the priority order. A reference model in the bench tracks the staged low word and the committed table on its own. It queues an expected hit and index for every strobe, including strobes that coincide with a commit, so that the staging and ordering rules are observed at the result port.

// File: rtl/uaf_pkg.sv
package uaf_pkg;

    localparam int MAC_W   = 48;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int VLD_POS = 31;

    // Word select carried in bit 0 of the register address
    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } uaf_sel_e;

    // One stored entry, little-endian bytes
    typedef struct packed {
        logic              vld;
        logic [HALF_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } uaf_entry_t;

    // Rebuild the wire-order address (byte 0 in the top byte)
    function automatic logic [MAC_W-1:0] words_to_mac(
        input logic [WORD_W-1:0] lo,
        input logic [HALF_W-1:0] hi
    );
        return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
    endfunction

    // Read-back image of the high register
    function automatic logic [WORD_W-1:0] hi_image(input uaf_entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[HALF_W-1:0] = e.hi;
        w[VLD_POS]    = e.vld;
        return w;
    endfunction

endpackage

// File: rtl/uaf_entry_store.sv
module uaf_entry_store
    import uaf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [IDX_W:0]                addr,
    input  logic [WORD_W-1:0]             wdata,
    output logic [WORD_W-1:0]             rdata,
    output uaf_entry_t [N_ENTRIES-1:0]    tbl
);

    uaf_entry_t [N_ENTRIES-1:0] tbl_q;

    // Staged low word, waiting for its high word
    logic                stg_vld;
    logic [IDX_W-1:0]    stg_idx;
    logic [WORD_W-1:0]   stg_lo;

    uaf_sel_e            sel;
    logic [IDX_W-1:0]    idx;
    logic                idx_ok;
    logic                commit;
    logic                stage;
    uaf_entry_t          cur_ent;
    uaf_entry_t          new_ent;

    assign sel    = uaf_sel_e'(addr[0]);
    assign idx    = addr[IDX_W:1];
    assign idx_ok = (32'(idx) < N_ENTRIES);
    assign commit = wr_en && idx_ok && (sel == SEL_HI);
    assign stage  = wr_en && idx_ok && (sel == SEL_LO);

    always_comb begin
        cur_ent = idx_ok ? tbl_q[idx] : '0;
        new_ent.lo  = (stg_vld && (stg_idx == idx)) ? stg_lo : cur_ent.lo;
        new_ent.hi  = wdata[HALF_W-1:0];
        new_ent.vld = |{new_ent.lo, new_ent.hi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (idx == IDX_W'(i)) tbl_q[i] <= new_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld <= 1'b0;
            stg_idx <= '0;
            stg_lo  <= '0;
        end else if (stage) begin
            stg_vld <= 1'b1;
            stg_idx <= idx;
            stg_lo  <= wdata;
        end else if (commit && stg_vld && (stg_idx == idx)) begin
            stg_vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (!idx_ok)           rdata <= '0;
            else if (sel == SEL_HI) rdata <= hi_image(cur_ent);
            else                   rdata <= cur_ent.lo;
        end
    end

    assign tbl = tbl_q;

endmodule

// File: rtl/uaf_prio_enc.sv
module uaf_prio_enc #(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic [N_ENTRIES-1:0] req,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    // Scan downward so the lowest set bit wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/uaf_match_array.sv
module uaf_match_array
    import uaf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  uaf_entry_t [N_ENTRIES-1:0] tbl,
    input  logic                       dest_valid,
    input  logic [MAC_W-1:0]           dest_addr,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic [IDX_W-1:0]           res_idx
);

    logic [N_ENTRIES-1:0] hit_vec;
    logic                 any_hit;
    logic [IDX_W-1:0]     first_idx;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = tbl[g].vld &&
                            (words_to_mac(tbl[g].lo, tbl[g].hi) == dest_addr);
    end

    uaf_prio_enc #(.N_ENTRIES(N_ENTRIES)) u_prio (
        .req (hit_vec),
        .any (any_hit),
        .idx (first_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
        end else begin
            res_valid <= dest_valid;
            res_hit   <= dest_valid && any_hit;
            res_idx   <= (dest_valid && any_hit) ? first_idx : '0;
        end
    end

endmodule

// File: rtl/ucast_addr_filter.sv
module ucast_addr_filter
    import uaf_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W:0]    reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dest_valid,
    input  logic [47:0]       dest_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_idx
);

    uaf_entry_t [N_ENTRIES-1:0] tbl;

    uaf_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .rd_en (reg_rd),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .tbl   (tbl)
    );

    uaf_match_array #(.N_ENTRIES(N_ENTRIES)) u_match (
        .clk        (clk),
        .rst        (rst),
        .tbl        (tbl),
        .dest_valid (dest_valid),
        .dest_addr  (dest_addr),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_idx    (res_idx)
    );

endmodule

// File: rtl/uaf_checker.sv
module uaf_checker #(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic [IDX_W:0]    reg_addr,
    input logic [31:0]       reg_rdata,
    input logic              dest_valid,
    input logic [47:0]       dest_addr,
    input logic              res_valid,
    input logic              res_hit,
    input logic [IDX_W-1:0]  res_idx
);

    assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (rst)
        dest_valid |=> res_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !dest_valid |=> !res_valid);

    assert_hit_qualified_R8: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid);

    assert_miss_idx_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_idx == '0));

    assert_zero_never_hits_R4: assert property (@(posedge clk) disable iff (rst)
        (dest_valid && (dest_addr == 48'h0)) |=> !res_hit);

    assert_hi_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr[0]) |=> (reg_rdata[30:16] == 15'h0));

endmodule

bind ucast_addr_filter uaf_checker #(.N_ENTRIES(N_ENTRIES)) u_uaf_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .dest_valid (dest_valid),
    .dest_addr  (dest_addr),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_idx    (res_idx)
);

// File: tb/ucast_addr_filter_test.sv
module ucast_addr_filter_test;

    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [IW:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          dest_valid = 1'b0;
    logic [47:0]   dest_addr = '0;
    logic          res_valid;
    logic          res_hit;
    logic [IW-1:0] res_idx;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ucast_addr_filter #(.N_ENTRIES(N)) uut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dest_valid(dest_valid), .dest_addr(dest_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
    );

    // Reference model
    logic [31:0] m_lo [N];
    logic [15:0] m_hi [N];
    logic        s_vld;
    int          s_idx;
    logic [31:0] s_lo;

    logic [IW:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [31:0] lo_of(input logic [47:0] a);
        return {a[23:16], a[31:24], a[39:32], a[47:40]};
    endfunction

    function automatic logic [15:0] hi_of(input logic [47:0] a);
        return {a[7:0], a[15:8]};
    endfunction

    function automatic logic [47:0] mac_of(input int i);
        return {m_lo[i][7:0], m_lo[i][15:8], m_lo[i][23:16], m_lo[i][31:24],
                m_hi[i][7:0], m_hi[i][15:8]};
    endfunction

    function automatic logic ent_vld(input int i);
        return |{m_lo[i], m_hi[i]};
    endfunction

    function automatic logic [IW:0] predict(input logic [47:0] a);
        for (int i = 0; i < N; i++) begin
            if (ent_vld(i) && mac_of(i) == a) return {1'b1, IW'(i)};
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(input int idx, input logic hi, input logic [31:0] d);
        if (!hi) begin
            s_vld = 1'b1; s_idx = idx; s_lo = d;
        end else begin
            if (s_vld && s_idx == idx) begin
                m_lo[idx] = s_lo; s_vld = 1'b0;
            end
            m_hi[idx] = d[15:0];
        end
    endtask

    task automatic wr(input int idx, input logic hi, input logic [31:0] d);
        model_write(idx, hi, d);
        reg_wr = 1'b1; reg_addr = {IW'(idx), hi}; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_entry(input int idx, input logic [47:0] a);
        wr(idx, 1'b0, lo_of(a));
        wr(idx, 1'b1, {16'h0, hi_of(a)});
    endtask

    task automatic send(input logic [47:0] a, input string tag);
        exp_q.push_back(predict(a)); tag_q.push_back(tag);
        dest_valid = 1'b1; dest_addr = a;
        @(negedge clk);
        dest_valid = 1'b0;
    endtask

    // High write and frame strobe in the same cycle (R9)
    task automatic wr_hi_send(input int idx, input logic [31:0] d,
                              input logic [47:0] a, input string tag);
        exp_q.push_back(predict(a)); tag_q.push_back(tag);
        model_write(idx, 1'b1, d);
        reg_wr = 1'b1; reg_addr = {IW'(idx), 1'b1}; reg_wdata = d;
        dest_valid = 1'b1; dest_addr = a;
        @(negedge clk);
        reg_wr = 1'b0; dest_valid = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic hi, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = {IW'(idx), hi};
        @(negedge clk);
        reg_rd = 1'b0;
        check(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R8 unexpected result actual=%b/%0d expected=none", res_hit, res_idx);
            end else begin
                logic [IW:0] e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(t, {31'h0, res_hit}, {31'h0, e[IW]});
                check(t, {{(32-IW){1'b0}}, res_idx}, {{(32-IW){1'b0}}, e[IW-1:0]});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    localparam logic [47:0] STA  = 48'h021B2C3D4E5F;
    localparam logic [47:0] DUP  = 48'h00AABBCCDDEE;
    localparam logic [47:0] OTH  = 48'h665544332211;
    localparam logic [47:0] LAST = 48'hF0E1D2C3B4A5;

    initial begin
        for (int i = 0; i < N; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        s_vld = 1'b0; s_idx = 0; s_lo = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 res_valid after reset", {31'h0, res_valid}, 32'h0);
        rd_chk(0, 1'b1, 32'h0, "R1 entry0 high after reset");
        rd_chk(N-1, 1'b0, 32'h0, "R1 last low after reset");
        send(48'h0, "R1 zero frame after reset");
        send(STA, "R1 station frame after reset");

        // Init: station address at entry 0, junk in upper write bits (R3)
        wr(0, 1'b0, 32'h3D2C1B02);
        wr(0, 1'b1, 32'hFFFF5F4E);
        for (int i = 1; i < N; i++) set_entry(i, 48'h0);
        rd_chk(0, 1'b0, 32'h3D2C1B02, "R2 low word byte order");
        rd_chk(0, 1'b1, 32'h80005F4E, "R3 high word valid and padding");
        rd_chk(1, 1'b1, 32'h0, "R4 zero entry invalid");
        send(STA, "R2 station hit entry 0");
        send(OTH, "R6 unknown miss");
        send(STA ^ 48'h1, "R6 one bit differs");
        send(48'h0, "R4 zero frame misses");

        // Priority across duplicates
        set_entry(9, DUP);
        send(DUP, "R6 single hit 9");
        set_entry(5, DUP);
        send(DUP, "R7 lowest of 5 and 9");
        send(DUP, "R7 back-to-back repeat");
        set_entry(N-1, LAST);
        send(LAST, "R6 last entry");

        // Staging rules
        wr(7, 1'b0, lo_of(OTH));
        rd_chk(7, 1'b0, 32'h0, "R5 staged low not visible");
        send({OTH[47:16], 16'h0}, "R5 staged low no match");
        wr(3, 1'b1, {16'h0, hi_of(OTH)});
        rd_chk(3, 1'b1, {16'h8000, hi_of(OTH)}, "R5 other index keeps own low");
        send(OTH, "R5 other entry still misses");
        wr_hi_send(7, {16'h0, hi_of(OTH)}, OTH, "R9 same-cycle strobe sees old table");
        send(OTH, "R5 committed entry 7 hits");
        rd_chk(7, 1'b0, lo_of(OTH), "R10 low after commit");

        // Read in same cycle as write returns old value (R10)
        reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = {IW'(5), 1'b1}; reg_wdata = 32'h0;
        model_write(5, 1'b1, 32'h0);
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        check("R10 read during write", reg_rdata, {16'h8000, hi_of(DUP)});

        // Clearing entry 5 fully invalidates it
        wr(5, 1'b0, 32'h0);
        wr(5, 1'b1, 32'h0);
        rd_chk(5, 1'b1, 32'h0, "R4 cleared entry invalid");
        send(DUP, "R7 falls back to 9");
        send(STA, "R6 station still hits");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R8 missing results actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule